// File: doc/BRIEF.md
# Static Memory Byte Lane Generator

This block turns the attributes of a bus transfer into the byte select pattern and word address seen by one external static memory bank. During the address phase of a pipelined slave interface it latches the direction, the transfer size, the low address bits, the byte order and the bank's configuration. During the following data phase it drives four active-low lane selects, an external address scaled to the bank's data width, and a two-cycle error response for sizes it cannot serve.

Reads and writes are treated differently. A write lowers only the selects of the bytes it touches, placed by the address and the byte order. A read ignores the address and, according to a per-bank read-lane-enable input, lowers all four selects for banks of byte-partitioned 16-bit or 32-bit devices, or leaves them all high for banks of 8-bit devices whose write strobes hang on the selects.

Top module: `smem_lane_gen`

## Requirements
- R1: After reset, and in any cycle that is not the data phase of an accepted transfer, `lane_n_o` is 4'b1111, `err_o` is 0 and `ready_o` is 1.
- R2: A transfer is accepted on a rising edge where `sel_i` and `ready_o` are both 1; its data phase is the next cycle, with `active_o` high. `size_i` encodes 0 = byte, 1 = halfword, 2 = word.
- R3: In the data phase of a read with `rd_lane_en_i` = 0, `lane_n_o` is 4'b1111.
- R4: In the data phase of a read with `rd_lane_en_i` = 1, `lane_n_o` is 4'b0000 whatever the low address bits.
- R5: On a 32-bit bank (`width_i` = 2), a little-endian write (`big_endian_i` = 0) lowers lane k for each byte address k (0..3) it covers; address bits below the transfer size are ignored.
- R6: In big-endian mode, a write lowers lane w-1-k for each covered byte offset k, where w is the bank width in bytes (byte 0 of a 32-bit bank is lane 3, halfword 0 is lanes 3:2).
- R7: On a 16-bit bank (`width_i` = 1), writes use only lanes 1:0, chosen from address bit 0; lanes 3:2 stay high.
- R8: On an 8-bit bank (`width_i` = 0), writes use only lane 0; lanes 3:1 stay high.
- R9: A write at least as wide as the bank lowers every lane of the bank.
- R10: During the data phase `ext_addr_o` equals the captured address shifted right by 0, 1 or 2 bits for `width_i` 0, 1 or 2.
- R11: A transfer with `size_i` above 2 yields one cycle with `err_o` = 1, `ready_o` = 0, then one cycle with `err_o` = 1, `ready_o` = 1; no lane is lowered and `sel_i` during the first cycle is ignored.
- R12: `width_i` = 3 behaves exactly like 2 (32-bit bank).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Transfer request in the address phase |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | Transfer size code |
| addr_i | input | ADDR_W | System byte address |
| big_endian_i | input | 1 | Byte order, 1 = big-endian |
| width_i | input | 2 | Bank width: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| rd_lane_en_i | input | 1 | Lower all lanes on reads when 1 |
| lane_n_o | output | 4 | Active-low byte lane selects |
| ext_addr_o | output | ADDR_W | Width-scaled external address |
| active_o | output | 1 | Data phase of an accepted, supported transfer |
| ready_o | output | 1 | Transfer may complete / next may be accepted |
| err_o | output | 1 | Error response |

## Verification
The hardest situation to reach is a request arriving while the first error cycle holds `ready_o` low: it must leave no trace, yet the request held into the second error cycle must then be taken. The sweep drives a word write with `sel_i` high straight after each errored transfer is seen, checks that the second error cycle still shows all lanes high, and runs every combination of direction, size code, low address, byte order, width and read-lane bit back to back so acceptance during the second error cycle is covered too.

// File: rtl/smem_lane_pkg.sv
package smem_lane_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_ERR1 = 2'd2,
    PH_ERR2 = 2'd3
  } phase_t;

  function automatic int bank_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic int addr_shift(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction

  // Active-high mask of the lanes a write touches.
  function automatic logic [LANES-1:0] write_mask(input logic [1:0] size,
                                                  input logic [1:0] off,
                                                  input logic [1:0] wcode,
                                                  input logic       be);
    int wb;
    int n;
    int nb;
    int start;
    logic [LANES-1:0] m;
    logic [LANES-1:0] r;
    wb    = bank_bytes(wcode);
    n     = 1 << size;
    nb    = (n < wb) ? n : wb;
    start = (n < wb) ? (int'(off) & (wb - 1) & ~(n - 1)) : 0;
    m     = LANES'(((1 << nb) - 1) << start);
    if (!be) return m;
    r = '0;
    for (int i = 0; i < LANES; i++)
      if (i < wb) r[wb - 1 - i] = m[i];
    return r;
  endfunction

endpackage

// File: rtl/smem_phase_ctrl.sv
module smem_phase_ctrl
  import smem_lane_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              be_i,
  input  logic [1:0]        width_i,
  input  logic              rle_i,
  output logic              active_o,
  output logic              ready_o,
  output logic              err_o,
  output logic              wr_q,
  output logic [1:0]        size_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              be_q,
  output logic [1:0]        width_q,
  output logic              rle_q
);

  phase_t state;
  logic   accept;
  logic   bad_size;

  assign accept   = sel_i && ready_o;
  assign bad_size = (size_i > 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      wr_q    <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      be_q    <= 1'b0;
      width_q <= '0;
      rle_q   <= 1'b0;
    end else if (state == PH_ERR1) begin
      state <= PH_ERR2;
    end else if (accept) begin
      state   <= bad_size ? PH_ERR1 : PH_DATA;
      wr_q    <= write_i;
      size_q  <= size_i[1:0];
      addr_q  <= addr_i;
      be_q    <= be_i;
      width_q <= width_i;
      rle_q   <= rle_i;
    end else begin
      state <= PH_IDLE;
    end
  end

  assign active_o = (state == PH_DATA);
  assign ready_o  = (state != PH_ERR1);
  assign err_o    = (state == PH_ERR1) || (state == PH_ERR2);

  // R11: the stalled error cycle is always followed by the completing one
  assert_err_second_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !ready_o) |=> (err_o && ready_o));

  // R11: an oversized request opens the error response
  assert_err_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ready_o && size_i > 3'd2) |=> (err_o && !ready_o && !active_o));

  // R2: a supported accepted request opens a data phase
  assert_accept_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && ready_o && size_i <= 3'd2) |=> (active_o && !err_o));

endmodule

// File: rtl/smem_lane_decode.sv
module smem_lane_decode
  import smem_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             wr_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       off_i,
  input  logic [1:0]       width_i,
  input  logic             be_i,
  input  logic             rle_i,
  output logic [LANES-1:0] lane_n_o
);

  logic [LANES-1:0] wmask;

  assign wmask = write_mask(size_i, off_i, width_i, be_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n_o[g] = !(active_i && (wr_i ? wmask[g] : rle_i));
  end

  // R1: outside a data phase every lane is high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> (lane_n_o == '1));

  // R3 R4: a read drives all lanes the same way
  assert_read_uniform_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !wr_i) |-> (lane_n_o == '1 || lane_n_o == '0));

  // R8: an 8-bit bank never lowers lanes 3:1
  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && wr_i && width_i == 2'd0) |-> (lane_n_o[3:1] == 3'b111 && !lane_n_o[0]));

  // R7: a 16-bit bank never lowers lanes 3:2
  assert_half_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && wr_i && width_i == 2'd1) |-> (lane_n_o[3:2] == 2'b11 && lane_n_o[1:0] != 2'b11));

endmodule

// File: rtl/smem_addr_xlate.sv
module smem_addr_xlate
  import smem_lane_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        width_i,
  output logic [ADDR_W-1:0] ext_addr_o
);

  always_comb begin
    ext_addr_o = addr_i >> addr_shift(width_i);
  end

endmodule

// File: rtl/smem_lane_gen.sv
module smem_lane_gen
  import smem_lane_pkg::*;
#(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              big_endian_i,
  input  logic [1:0]        width_i,
  input  logic              rd_lane_en_i,
  output logic [3:0]        lane_n_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic              active_o,
  output logic              ready_o,
  output logic              err_o
);

  logic              wr_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              be_q;
  logic [1:0]        width_q;
  logic              rle_q;

  smem_phase_ctrl #(.ADDR_W(ADDR_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_i    (sel_i),
    .write_i  (write_i),
    .size_i   (size_i),
    .addr_i   (addr_i),
    .be_i     (big_endian_i),
    .width_i  (width_i),
    .rle_i    (rd_lane_en_i),
    .active_o (active_o),
    .ready_o  (ready_o),
    .err_o    (err_o),
    .wr_q     (wr_q),
    .size_q   (size_q),
    .addr_q   (addr_q),
    .be_q     (be_q),
    .width_q  (width_q),
    .rle_q    (rle_q)
  );

  smem_lane_decode u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active_o),
    .wr_i     (wr_q),
    .size_i   (size_q),
    .off_i    (addr_q[1:0]),
    .width_i  (width_q),
    .be_i     (be_q),
    .rle_i    (rle_q),
    .lane_n_o (lane_n_o)
  );

  smem_addr_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .addr_i     (addr_q),
    .width_i    (width_q),
    .ext_addr_o (ext_addr_o)
  );

  // R11: no lane is lowered while an error response is shown
  assert_err_no_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (lane_n_o == 4'hF && !active_o));

endmodule

// File: tb/smem_lane_gen_bench.sv
module smem_lane_gen_bench;

  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_i = 1'b0;
  logic          write_i = 1'b0;
  logic [2:0]    size_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic          big_endian_i = 1'b0;
  logic [1:0]    width_i = '0;
  logic          rd_lane_en_i = 1'b0;
  logic [3:0]    lane_n_o;
  logic [AW-1:0] ext_addr_o;
  logic          active_o;
  logic          ready_o;
  logic          err_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  smem_lane_gen #(.ADDR_W(AW)) u_smem_lane_gen (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .write_i(write_i), .size_i(size_i),
    .addr_i(addr_i), .big_endian_i(big_endian_i), .width_i(width_i),
    .rd_lane_en_i(rd_lane_en_i), .lane_n_o(lane_n_o), .ext_addr_o(ext_addr_o),
    .active_o(active_o), .ready_o(ready_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected active-low lanes, counted lane by lane from the bank's point of view.
  function automatic logic [3:0] model_lanes(input bit wr, input int sz, input int a2,
                                             input bit be, input int wc, input bit rle);
    int wb;
    int blk;
    int base;
    logic [3:0] r;
    if (!wr) return rle ? 4'h0 : 4'hF;
    wb   = (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
    blk  = ((1 << sz) < wb) ? (1 << sz) : wb;
    base = ((a2 % wb) / blk) * blk;
    r = 4'hF;
    for (int l = 0; l < wb; l++) begin
      int k;
      k = be ? (wb - 1 - l) : l;
      if (k >= base && k < base + blk) r[l] = 1'b0;
    end
    return r;
  endfunction

  function automatic string lane_req(input bit wr, input bit rle, input bit be, input int wc,
                                     input int sz);
    if (!wr) return rle ? "R4" : "R3";
    if (wc == 3) return "R12";
    if ((1 << sz) >= ((wc == 0) ? 1 : (wc == 1) ? 2 : 4)) return "R9";
    if (wc == 0) return "R8";
    if (wc == 1) return "R7";
    return be ? "R6" : "R5";
  endfunction

  // Called at a falling edge; returns at the falling edge of the last response cycle.
  task automatic issue(input bit wr, input int sz, input logic [AW-1:0] a, input bit be,
                       input int wc, input bit rle);
    sel_i = 1'b1; write_i = wr; size_i = 3'(sz); addr_i = a;
    big_endian_i = be; width_i = 2'(wc); rd_lane_en_i = rle;
    @(posedge clk); @(negedge clk);
    if (sz > 2) begin
      chk("R11 err first", {29'd0, err_o, ready_o, active_o}, 32'h4);
      chk("R11 lanes", 32'(lane_n_o), 32'hF);
      // A request during the stalled cycle must be ignored
      sel_i = 1'b1; write_i = 1'b1; size_i = 3'd2; width_i = 2'd2; rd_lane_en_i = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R11 err second", {29'd0, err_o, ready_o, active_o}, 32'h6);
      chk("R11 ignored request", 32'(lane_n_o), 32'hF);
    end else begin
      chk("R2 data phase", {29'd0, err_o, ready_o, active_o}, 32'h3);
      chk(lane_req(wr, rle, be, wc, sz), 32'(lane_n_o),
          32'(model_lanes(wr, sz, int'(a[1:0]), be, wc, rle)));
      chk(wc == 3 ? "R12 addr" : "R10 addr", 32'(ext_addr_o),
          32'(a / ((wc == 0) ? 1 : (wc == 1) ? 2 : 4)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lanes", 32'(lane_n_o), 32'hF);
    chk("R1 reset flags", {29'd0, err_o, ready_o, active_o}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {28'd0, lane_n_o}, 32'hF);
    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz < 8; sz++)
        for (int lo = 0; lo < 4; lo++)
          for (int be = 0; be < 2; be++)
            for (int wc = 0; wc < 4; wc++)
              for (int rle = 0; rle < 2; rle++) begin
                logic [AW-1:0] a;
                a = AW'((((wr * 131) + (sz * 57) + (be * 29) + (wc * 11) + rle) * 4093) << 2) | AW'(lo);
                issue(wr[0], sz, a, be[0], wc, rle[0]);
              end
    sel_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 idle lanes", 32'(lane_n_o), 32'hF);
    chk("R1 idle flags", {29'd0, err_o, ready_o, active_o}, 32'h2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule